// File: doc/BRIEF.md
# PCI Base Address Register Bank with Sizing

This block holds the base address registers of one PCI function header and carries out the sizing exchange that enumeration software relies on. A configuration access router presents one access per cycle. Each access carries a byte offset into the 256-byte header, a byte count, write data and a write strobe. The bank answers reads combinationally with the addressed bytes.

Each slot has a fixed type, I/O or memory, and a fixed power-of-two size, both chosen by parameters. A slot whose reset value is zero counts as not implemented. To size a slot, software writes all ones and reads the slot back. The bank then returns the two's-complement size mask, and software gets the size as the bitwise inverse plus one. Software then writes the real base address. In every write the low type bits stay hard-wired to their reset values. The interrupt pin byte reads as INTA. All other header registers are decoded elsewhere.

Top module: `bar_bank`

## Requirements
- R1: After reset, each slot holds its parameter reset value. Slot i is read as a 32-bit word at byte offset 0x10 + 4*i.
- R2: Offsets 0x10 up to 0x10 + 4*NBAR - 1 select slot (offset - 0x10) / 4. A write to any other offset leaves every slot unchanged.
- R3: A write of 0xFFFFFFFF with offset bits 1:0 equal to 0 and a count of 4 or more makes the slot read as ~(size - 1), with its type bits merged back in.
- R4: The writable bits are 31:2 for an I/O slot and 31:4 for a memory slot. The bits outside that mask never change from their reset values.
- R5: A write to a slot whose current contents are zero is ignored. This covers unimplemented slots and memory slots that software has written to zero.
- R6: Any other write stores the written bits inside the writable mask, so a normal base address lands in the slot.
- R7: A write of count n at byte lane l = offset[1:0] sets lane l+k from data byte k, for k < n and l+k < 4. Other lanes keep their values. A write of all ones that covers less than a full word is treated as plain data.
- R8: A count of 0 moves no bytes. Counts of 5 to 7 act as 4.
- R9: Read byte k equals register byte offset[1:0]+k when k < count and offset[1:0]+k < 4. Otherwise that byte is zero. Offsets that fall on neither a slot nor the interrupt pin read as zero.
- R10: The byte at offset 0x3D, the interrupt pin, reads as 0x01, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the current access |
| cfg_off | input | AW | Byte offset into the function header |
| cfg_size | input | 3 | Byte count of the access (0 to 7, clamped to 4) |
| cfg_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| cfg_rdata | output | 32 | Read data for the current offset and count |

## Verification
The bench uses the default parameters. These give two I/O slots, one of them at the smallest size of 4 bytes, and three memory slots, one of them at the smallest size of 16 bytes and one with its prefetchable bit set, plus one unimplemented slot. With this mix, every size mask edge can be reached: an I/O slot whose writable bits sit right next to its type bits, and a memory slot whose mask holds only type bits. Both zero-slot cases are covered too: a slot that starts at zero, and a slot that software writes to zero.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

   localparam int unsigned HDR_BAR_BASE = 'h10;
   localparam int unsigned HDR_PIN_DW   = 'h3C / 4;
   localparam int unsigned WORD_BYTES   = 4;

   typedef logic [31:0] word_t;

   // bits software may change in a slot of the given type
   function automatic word_t writable_mask(input logic is_io);
      return is_io ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
   endfunction

   // lanes touched by an access of count sz starting at lane lo
   function automatic logic [3:0] lanes(input logic [1:0] lo, input logic [2:0] sz);
      logic [2:0] n;
      logic [7:0] m;
      n = (sz > 3'd4) ? 3'd4 : sz;
      m = 8'h0F >> (3'd4 - n);
      m = m << lo;
      return m[3:0];
   endfunction

endpackage

// File: rtl/bar_addr_decode.sv
module bar_addr_decode #(
   parameter int AW   = 8,
   parameter int NBAR = 6,
   localparam int IW  = (NBAR > 1) ? $clog2(NBAR) : 1
) (
   input  logic [AW-1:0] off,
   output logic          hit,
   output logic [IW-1:0] idx,
   output logic          pin_hit
);
   import bar_bank_pkg::*;

   localparam logic [AW-1:0] WIN_LO = AW'(HDR_BAR_BASE);
   localparam logic [AW-1:0] WIN_HI = AW'(HDR_BAR_BASE + WORD_BYTES * NBAR);

   logic [AW-1:0] rel;

   always_comb begin
      rel     = off - WIN_LO;
      hit     = (off >= WIN_LO) && (off < WIN_HI);
      idx     = IW'(rel >> 2);
      pin_hit = (off[AW-1:2] == (AW-2)'(HDR_PIN_DW));
   end
endmodule

// File: rtl/bar_slot.sv
module bar_slot #(
   parameter int          LOG2  = 12,
   parameter bit          IS_IO = 1'b0,
   parameter logic [31:0] INIT  = 32'hC000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [3:0]  lane_en,
   input  logic        size_req,
   input  logic [31:0] wdata_sh,
   output logic [31:0] q
);
   import bar_bank_pkg::*;

   localparam logic [31:0] SIZE_MASK = ~((32'd1 << LOG2) - 32'd1);

   logic [31:0] wm, cand, merged, nxt;

   generate
      if (IS_IO) begin : g_io
         assign wm = writable_mask(1'b1);
      end else begin : g_mem
         assign wm = writable_mask(1'b0);
      end
   endgenerate

   always_comb begin
      cand   = size_req ? SIZE_MASK : wdata_sh;
      merged = (cand & wm) | (q & ~wm);
      for (int b = 0; b < 4; b++)
         nxt[8*b +: 8] = lane_en[b] ? merged[8*b +: 8] : q[8*b +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= INIT;
      else if (we && (q != '0))
         q <= nxt;
   end
endmodule

// File: rtl/bar_read_mux.sv
module bar_read_mux #(
   parameter int NBAR = 6,
   localparam int IW  = (NBAR > 1) ? $clog2(NBAR) : 1
) (
   input  logic [NBAR-1:0][31:0] bar_q,
   input  logic                  hit,
   input  logic [IW-1:0]         idx,
   input  logic                  pin_hit,
   input  logic [1:0]            lo,
   input  logic [2:0]            sz,
   output logic [31:0]           rdata
);
   import bar_bank_pkg::*;

   logic [31:0] word, shifted;
   logic [3:0]  rmask;

   always_comb begin
      word = '0;
      if (pin_hit)
         word = 32'h0000_0100;
      for (int i = 0; i < NBAR; i++)
         if (hit && (idx == IW'(i)))
            word = bar_q[i];
      shifted = word >> {lo, 3'b000};
      rmask   = lanes(lo, sz) >> lo;
      for (int b = 0; b < 4; b++)
         rdata[8*b +: 8] = rmask[b] ? shifted[8*b +: 8] : 8'h00;
   end
endmodule

// File: rtl/bar_bank.sv
module bar_bank #(
   parameter int                     NBAR     = 6,
   parameter int                     AW       = 8,
   parameter logic [NBAR-1:0][5:0]   BAR_LOG2 = {6'd4, 6'd0, 6'd2, 6'd16, 6'd8, 6'd12},
   parameter logic [NBAR-1:0]        BAR_IO   = 6'b001010,
   parameter logic [NBAR-1:0][31:0]  BAR_INIT = {32'hE000_0000, 32'h0000_0000,
                                                 32'h0000_D001, 32'hD000_0008,
                                                 32'h0000_C001, 32'hC000_0000}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [AW-1:0] cfg_off,
   input  logic [2:0]    cfg_size,
   input  logic [31:0]   cfg_wdata,
   output logic [31:0]   cfg_rdata
);
   import bar_bank_pkg::*;

   localparam int IW = (NBAR > 1) ? $clog2(NBAR) : 1;

   if (NBAR < 1 || NBAR > 6) begin : g_bad_nbar
      $error("bar_bank: NBAR must be 1..6");
   end
   if (AW < 8) begin : g_bad_aw
      $error("bar_bank: AW must cover a 256-byte header");
   end

   logic                 hit, pin_hit, size_req;
   logic [IW-1:0]        idx;
   logic [3:0]           lane_en;
   logic [31:0]          wdata_sh;
   logic [NBAR-1:0][31:0] bar_q;

   bar_addr_decode #(.AW(AW), .NBAR(NBAR)) u_dec (
      .off(cfg_off), .hit(hit), .idx(idx), .pin_hit(pin_hit)
   );

   always_comb begin
      lane_en  = lanes(cfg_off[1:0], cfg_size);
      wdata_sh = cfg_wdata << {cfg_off[1:0], 3'b000};
      size_req = (cfg_off[1:0] == 2'd0) && (cfg_size >= 3'd4) && (cfg_wdata == 32'hFFFF_FFFF);
   end

   for (genvar i = 0; i < NBAR; i++) begin : g_bar
      localparam int MIN_LOG2 = BAR_IO[i] ? 2 : 4;
      localparam logic [31:0] ALIGN = (32'd1 << BAR_LOG2[i]) - 32'd1;
      if (BAR_LOG2[i] != 0) begin : g_chk
         if (int'(BAR_LOG2[i]) < MIN_LOG2 || BAR_LOG2[i] > 6'd31) begin : g_bad_size
            $error("bar_bank: slot size out of range");
         end
         if (BAR_INIT[i] == 32'h0) begin : g_bad_init
            $error("bar_bank: implemented slot needs a nonzero reset value");
         end
         if (BAR_INIT[i][0] != BAR_IO[i]) begin : g_bad_type
            $error("bar_bank: reset value type bit disagrees with BAR_IO");
         end
         if ((BAR_INIT[i] & ALIGN & writable_mask(BAR_IO[i])) != 32'h0) begin : g_bad_align
            $error("bar_bank: reset address not aligned to slot size");
         end
      end else begin : g_off
         if (BAR_INIT[i] != 32'h0) begin : g_bad_unimpl
            $error("bar_bank: unimplemented slot must reset to zero");
         end
      end

      bar_slot #(
         .LOG2 (int'(BAR_LOG2[i])),
         .IS_IO(BAR_IO[i]),
         .INIT (BAR_INIT[i])
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (cfg_wr && hit && (idx == IW'(i))),
         .lane_en (lane_en),
         .size_req(size_req),
         .wdata_sh(wdata_sh),
         .q       (bar_q[i])
      );
   end

   bar_read_mux #(.NBAR(NBAR)) u_rd (
      .bar_q  (bar_q),
      .hit    (hit),
      .idx    (idx),
      .pin_hit(pin_hit),
      .lo     (cfg_off[1:0]),
      .sz     (cfg_size),
      .rdata  (cfg_rdata)
   );
endmodule

// File: rtl/bar_bank_chk.sv
module bar_bank_chk #(
   parameter int                    NBAR     = 6,
   parameter int                    AW       = 8,
   parameter logic [NBAR-1:0][5:0]  BAR_LOG2 = {6'd4, 6'd0, 6'd2, 6'd16, 6'd8, 6'd12},
   parameter logic [NBAR-1:0]       BAR_IO   = 6'b001010
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_wr,
   input logic [AW-1:0]         cfg_off,
   input logic [2:0]            cfg_size,
   input logic [31:0]           cfg_wdata,
   input logic [31:0]           cfg_rdata,
   input logic [NBAR-1:0][31:0] bar_q
);
   logic in_win, full_ones;
   assign in_win    = (int'(cfg_off) >= 'h10) && (int'(cfg_off) < 'h10 + 4*NBAR);
   assign full_ones = (cfg_off[1:0] == 2'd0) && (cfg_size >= 3'd4) && (cfg_wdata == 32'hFFFF_FFFF);

   // R2: writes outside the slot window touch no slot
   p_outside_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !in_win) |=> $stable(bar_q));

   // R8: a zero-count write moves nothing
   p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_size == 3'd0) |=> $stable(bar_q));

   // R10: interrupt pin byte
   p_pin_reads_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_off) == 'h3D && cfg_size != 3'd0) |-> (cfg_rdata[7:0] == 8'h01));

   for (genvar i = 0; i < NBAR; i++) begin : g_p
      localparam logic [31:0] WM = BAR_IO[i] ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
      localparam logic [31:0] SM = ~((32'd1 << BAR_LOG2[i]) - 32'd1);

      // R4: hard-wired type bits never move
      p_type_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $stable(bar_q[i] & ~WM));

      // R5: a zero slot stays zero
      p_zero_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bar_q[i] == 32'h0) |=> (bar_q[i] == 32'h0));

      // R3: sizing write yields the size mask
      p_sizing_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_wr && full_ones && int'(cfg_off) == 'h10 + 4*i && bar_q[i] != 32'h0)
         |=> ((bar_q[i] & WM) == (SM & WM)));
   end
endmodule

bind bar_bank bar_bank_chk #(
   .NBAR(NBAR), .AW(AW), .BAR_LOG2(BAR_LOG2), .BAR_IO(BAR_IO)
) u_chk (.*);

// File: tb/bar_bank_test.sv
module bar_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_off = 8'h00;
   logic [2:0]  cfg_size = 3'd0;
   logic [31:0] cfg_wdata = 32'h0;
   logic [31:0] cfg_rdata;

   int total = 0;
   int fails = 0;
   string cur_req = "R1";

   localparam int          TB_LOG2 [6] = '{12, 8, 16, 2, 0, 4};
   localparam bit          TB_IO   [6] = '{0, 1, 0, 1, 0, 0};
   localparam logic [31:0] TB_INIT [6] = '{32'hC000_0000, 32'h0000_C001, 32'hD000_0008,
                                           32'h0000_D001, 32'h0000_0000, 32'hE000_0000};

   logic [31:0] m [6];

   always #2 clk = ~clk;

   bar_bank uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
      .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
   );

   function automatic logic [31:0] mwrite(input logic [31:0] old, input int i);
      int n, lo, bi;
      logic [31:0] wm, nv;
      n  = (cfg_size > 4) ? 4 : int'(cfg_size);
      lo = int'(cfg_off) % 4;
      wm = TB_IO[i] ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
      if (old == 32'h0) return old;
      if (n == 4 && lo == 0 && cfg_wdata == 32'hFFFF_FFFF)
         return (~((32'd1 << TB_LOG2[i]) - 32'd1) & wm) | (old & ~wm);
      nv = old;
      for (int k = 0; k < n; k++)
         if (lo + k < 4)
            for (int j = 0; j < 8; j++) begin
               bi = 8 * (lo + k) + j;
               if (wm[bi]) nv[bi] = cfg_wdata[8*k + j];
            end
      return nv;
   endfunction

   function automatic logic [31:0] mread();
      int n, lo, o;
      logic [31:0] w, r;
      o  = int'(cfg_off);
      n  = (cfg_size > 4) ? 4 : int'(cfg_size);
      lo = o % 4;
      if (o >= 'h10 && o < 'h28) w = m[(o - 'h10) / 4];
      else if (o / 4 == 'h3C / 4) w = 32'h0000_0100;
      else w = 32'h0;
      r = 32'h0;
      for (int k = 0; k < n; k++)
         if (lo + k < 4) r[8*k +: 8] = w[8*(lo+k) +: 8];
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) m[i] <= TB_INIT[i];
      end else if (cfg_wr) begin
         for (int i = 0; i < 6; i++)
            if (int'(cfg_off) >= 'h10 + 4*i && int'(cfg_off) < 'h14 + 4*i)
               m[i] <= mwrite(m[i], i);
      end
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: off=%h size=%0d actual=%h expected=%h", req, cfg_off, cfg_size, act, exp);
      end
   endtask

   // reference compare on every clock
   always @(negedge clk) begin
      if (rst_n) check(cfg_rdata, mread(), cur_req);
   end

   task automatic wr(input logic [7:0] o, input logic [2:0] s, input logic [31:0] d, input string req);
      @(posedge clk); #1;
      cur_req = req; cfg_wr = 1'b1; cfg_off = o; cfg_size = s; cfg_wdata = d;
   endtask

   task automatic expect_rd(input logic [7:0] o, input logic [2:0] s, input logic [31:0] e, input string req);
      @(posedge clk); #1;
      cur_req = req; cfg_wr = 1'b0; cfg_off = o; cfg_size = s; cfg_wdata = 32'h0;
      @(negedge clk); #0.5;
      check(cfg_rdata, e, req);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset values
      expect_rd(8'h10, 3'd4, 32'hC000_0000, "R1");
      expect_rd(8'h14, 3'd4, 32'h0000_C001, "R1");
      expect_rd(8'h18, 3'd4, 32'hD000_0008, "R1");
      expect_rd(8'h1C, 3'd4, 32'h0000_D001, "R1");
      expect_rd(8'h20, 3'd4, 32'h0000_0000, "R1");
      expect_rd(8'h24, 3'd4, 32'hE000_0000, "R1");
      // R3 sizing on every slot, R4 type bits kept, R5 unimplemented
      wr(8'h10, 3'd4, 32'hFFFF_FFFF, "R3"); expect_rd(8'h10, 3'd4, 32'hFFFF_F000, "R3");
      wr(8'h14, 3'd4, 32'hFFFF_FFFF, "R4"); expect_rd(8'h14, 3'd4, 32'hFFFF_FF01, "R4");
      wr(8'h18, 3'd4, 32'hFFFF_FFFF, "R4"); expect_rd(8'h18, 3'd4, 32'hFFFF_0008, "R4");
      wr(8'h1C, 3'd4, 32'hFFFF_FFFF, "R3"); expect_rd(8'h1C, 3'd4, 32'hFFFF_FFFD, "R3");
      wr(8'h20, 3'd4, 32'hFFFF_FFFF, "R5"); expect_rd(8'h20, 3'd4, 32'h0000_0000, "R5");
      wr(8'h24, 3'd4, 32'hFFFF_FFFF, "R3"); expect_rd(8'h24, 3'd4, 32'hFFFF_FFF0, "R3");
      // R6 address writes with mask merge
      wr(8'h10, 3'd4, 32'h8000_1234, "R6"); expect_rd(8'h10, 3'd4, 32'h8000_1230, "R6");
      wr(8'h14, 3'd4, 32'h0000_AB02, "R6"); expect_rd(8'h14, 3'd4, 32'h0000_AB01, "R6");
      wr(8'h18, 3'd4, 32'h1234_567F, "R6"); expect_rd(8'h18, 3'd4, 32'h1234_5678, "R6");
      // R7 sub-word writes
      wr(8'h11, 3'd2, 32'h0000_BEEF, "R7"); expect_rd(8'h10, 3'd4, 32'h80BE_EF30, "R7");
      wr(8'h13, 3'd2, 32'h0000_77AA, "R7"); expect_rd(8'h10, 3'd4, 32'hAABE_EF30, "R7");
      wr(8'h10, 3'd1, 32'h0000_00FF, "R7"); expect_rd(8'h10, 3'd4, 32'hAABE_EFF0, "R7");
      // R8 count encodings
      wr(8'h10, 3'd0, 32'h5555_5555, "R8"); expect_rd(8'h10, 3'd4, 32'hAABE_EFF0, "R8");
      wr(8'h10, 3'd7, 32'h1111_1111, "R8"); expect_rd(8'h10, 3'd4, 32'h1111_1110, "R8");
      wr(8'h10, 3'd5, 32'hFFFF_FFFF, "R8"); expect_rd(8'h10, 3'd4, 32'hFFFF_F000, "R8");
      // R5 memory slot written to zero then frozen
      wr(8'h24, 3'd4, 32'h0000_0000, "R5"); expect_rd(8'h24, 3'd4, 32'h0000_0000, "R5");
      wr(8'h24, 3'd4, 32'hE000_0000, "R5"); expect_rd(8'h24, 3'd4, 32'h0000_0000, "R5");
      // R2 writes outside the window
      wr(8'h0C, 3'd4, 32'h1234_5678, "R2");
      wr(8'h28, 3'd4, 32'h8765_4321, "R2");
      wr(8'h3D, 3'd1, 32'h0000_0004, "R10");
      expect_rd(8'h10, 3'd4, 32'hFFFF_F000, "R2");
      expect_rd(8'h14, 3'd4, 32'h0000_AB01, "R2");
      expect_rd(8'h18, 3'd4, 32'h1234_5678, "R2");
      expect_rd(8'h1C, 3'd4, 32'hFFFF_FFFD, "R2");
      expect_rd(8'h20, 3'd4, 32'h0000_0000, "R2");
      expect_rd(8'h24, 3'd4, 32'h0000_0000, "R2");
      // R9 read lane selection
      expect_rd(8'h19, 3'd2, 32'h0000_3456, "R9");
      expect_rd(8'h1B, 3'd4, 32'h0000_0012, "R9");
      expect_rd(8'h08, 3'd4, 32'h0000_0000, "R9");
      expect_rd(8'h1A, 3'd0, 32'h0000_0000, "R9");
      // R10 interrupt pin
      expect_rd(8'h3D, 3'd1, 32'h0000_0001, "R10");
      expect_rd(8'h3C, 3'd4, 32'h0000_0100, "R10");
      @(posedge clk);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule